// File: doc/BRIEF.md
# Trap Status and Origin Capture Unit

This block tracks processor trap events and holds two pieces of state for the core. The first is a trap-active flag. It supplies the most significant bit of the 4-bit CPU priority level. Traps outrank every user interrupt, so this bit raises the level above all of them. Hardware sets the flag whenever a trap is taken. Software may clear it but can never set it. Clearing the flag lets a handler send execution to any address it chooses, not only to the instruction after the one that faulted.

The second piece of state is a trap origin register. It records the program counter of the first trap that arrives while the current priority level is below 8. After it has captured a value it locks and keeps that address for debugging, and later traps leave it unchanged. Software clears the register and re-arms capture by writing zero to it. Vector selection and the separate trap sources belong to other blocks.

Top module: `trap_capture_unit`

## Requirements
- R1: After asynchronous reset, `trap_act_o` is 0, `orig_addr_o` is 0 and `orig_valid_o` is 0.
- R2: A cycle with `trap_evt_i` high makes `trap_act_o` 1 from the next clock edge onward.
- R3: A write with `wr_sel_i`=0 (status target) and `wr_data_i[0]`=0 clears `trap_act_o` at the next edge. A status write with bit 0 set leaves the flag unchanged, so software can never set it.
- R4: When a status clear and `trap_evt_i` arrive in the same cycle, `trap_act_o` is 1 afterwards.
- R5: A trap while `cur_lvl_i` < 8 and `orig_valid_o`=0 loads `trap_pc_i` into `orig_addr_o` and sets `orig_valid_o` at the next edge.
- R6: A trap while `cur_lvl_i` >= 8 does not change `orig_addr_o` or `orig_valid_o`.
- R7: While `orig_valid_o`=1 and no clear is written, traps do not change `orig_addr_o`.
- R8: A write with `wr_sel_i`=1 (origin target) and `wr_data_i`=0 sets `orig_addr_o` to 0 and `orig_valid_o` to 0 at the next edge, which re-arms capture.
- R9: A write with `wr_sel_i`=1 and any non-zero `wr_data_i` has no effect on the origin register.
- R10: When an origin clear and a trap with `cur_lvl_i` < 8 arrive in the same cycle, the clear is applied first, so the new `trap_pc_i` is captured and `orig_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_evt_i | input | 1 | Single-cycle pulse when a trap is taken |
| trap_pc_i | input | ADDR_W | Program counter of the faulting instruction |
| cur_lvl_i | input | LVL_W | Current CPU priority level |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 1 | Write target: 0 for the status flag, 1 for the origin register |
| wr_data_i | input | ADDR_W | Software write data |
| trap_act_o | output | 1 | Trap-active flag (bit 3 of the priority level) |
| orig_addr_o | output | ADDR_W | Captured trap origin address |
| orig_valid_o | output | 1 | Origin captured and locked |

## Verification
The bench builds the block with its default parameters: a 24-bit address and a 4-bit level. With a 4-bit level, all sixteen values of `cur_lvl_i` can be drawn at random, so the stimulus lands on both sides of the boundary at 8. With a 24-bit address, random program counters exercise the full register width, and zero can be written as a clear while non-zero values must be ignored. The directed cases force the same-cycle collisions of clear and trap on both registers.

// File: rtl/trap_cap_pkg.sv
package trap_cap_pkg;
  typedef enum logic {
    SEL_STAT = 1'b0,
    SEL_ORIG = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/tcu_wr_decode.sv
module tcu_wr_decode
  import trap_cap_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic              flag_clr_o,
  output logic              orig_clr_o
);
  wr_sel_e sel;
  assign sel = wr_sel_e'(wr_sel_i);

  // status target: only a 0 in bit 0 acts; a 1 can never set the flag
  assign flag_clr_o = wr_en_i && (sel == SEL_STAT) && !wr_data_i[0];
  // origin target: only an all-zero write acts
  assign orig_clr_o = wr_en_i && (sel == SEL_ORIG) && (wr_data_i == '0);
endmodule

// File: rtl/tcu_flag.sv
module tcu_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // hardware set wins over software clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/tcu_origin.sv
module tcu_origin #(
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  localparam logic [LVL_W-1:0] LVL_LIMIT = LVL_W'(1) << (LVL_W - 1);

  logic lvl_ok, armed, capture;
  assign lvl_ok  = lvl_i < LVL_LIMIT;
  assign armed   = !valid_o || clr_i;  // clear applies before capture
  assign capture = trap_i && lvl_ok && armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else if (capture) begin
      addr_o  <= pc_i;
      valid_o <= 1'b1;
    end else if (clr_i) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_capture_unit.sv
module trap_capture_unit #(
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_evt_i,
  input  logic [ADDR_W-1:0] trap_pc_i,
  input  logic [LVL_W-1:0]  cur_lvl_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic              trap_act_o,
  output logic [ADDR_W-1:0] orig_addr_o,
  output logic              orig_valid_o
);
  logic flag_clr, orig_clr;

  tcu_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .flag_clr_o(flag_clr),
    .orig_clr_o(orig_clr)
  );

  tcu_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (trap_evt_i),
    .clr_i (flag_clr),
    .flag_o(trap_act_o)
  );

  tcu_origin #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_orig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trap_i (trap_evt_i),
    .pc_i   (trap_pc_i),
    .lvl_i  (cur_lvl_i),
    .clr_i  (orig_clr),
    .addr_o (orig_addr_o),
    .valid_o(orig_valid_o)
  );
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker #(
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trap_evt_i,
  input logic [ADDR_W-1:0] trap_pc_i,
  input logic [LVL_W-1:0]  cur_lvl_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [ADDR_W-1:0] wr_data_i,
  input logic              trap_act_o,
  input logic [ADDR_W-1:0] orig_addr_o,
  input logic              orig_valid_o
);
  logic st_clr, or_clr, or_wr_nz, lvl_hi;
  assign st_clr   = wr_en_i && !wr_sel_i && !wr_data_i[0];
  assign or_clr   = wr_en_i && wr_sel_i && (wr_data_i == '0);
  assign or_wr_nz = wr_en_i && wr_sel_i && (wr_data_i != '0);
  assign lvl_hi   = cur_lvl_i[LVL_W-1];

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_evt_i |=> trap_act_o); // R2 R4
  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_clr && !trap_evt_i) |=> !trap_act_o); // R3
  AST_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_evt_i && !trap_act_o) |=> !trap_act_o); // R3
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_evt_i && !lvl_hi && (!orig_valid_o || or_clr))
      |=> (orig_valid_o && orig_addr_o == $past(trap_pc_i))); // R5 R10
  AST_HIGH_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_evt_i && lvl_hi && !wr_en_i) |=> ($stable(orig_addr_o) && $stable(orig_valid_o))); // R6
  AST_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (orig_valid_o && !or_clr) |=> (orig_valid_o && $stable(orig_addr_o))); // R7
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (or_clr && !(trap_evt_i && !lvl_hi)) |=> (!orig_valid_o && orig_addr_o == '0)); // R8
  AST_NZ_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (or_wr_nz && !trap_evt_i) |=> ($stable(orig_addr_o) && $stable(orig_valid_o))); // R9
  AST_RESET_VALUE: assert property (@(posedge clk_i)
    !rst_ni |-> (!trap_act_o && !orig_valid_o && orig_addr_o == '0)); // R1
endmodule

bind trap_capture_unit tcu_checker #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trap_evt_i  (trap_evt_i),
  .trap_pc_i   (trap_pc_i),
  .cur_lvl_i   (cur_lvl_i),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .trap_act_o  (trap_act_o),
  .orig_addr_o (orig_addr_o),
  .orig_valid_o(orig_valid_o)
);

// File: tb/trap_capture_unit_tb_top.sv
module trap_capture_unit_tb_top;
  localparam int ADDR_W = 24;
  localparam int LVL_W  = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_RAND = 3000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              trap_evt_i = 1'b0;
  logic [ADDR_W-1:0] trap_pc_i = '0;
  logic [LVL_W-1:0]  cur_lvl_i = '0;
  logic              wr_en_i = 1'b0;
  logic              wr_sel_i = 1'b0;
  logic [ADDR_W-1:0] wr_data_i = '0;
  logic              trap_act_o;
  logic [ADDR_W-1:0] orig_addr_o;
  logic              orig_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  logic              m_flag = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic              m_valid = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trap_capture_unit #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) dut_i (.*);

  function automatic logic f_flag(logic cur, logic trap, logic we, logic sel, logic [ADDR_W-1:0] d);
    if (trap) return 1'b1;
    if (we && !sel && !d[0]) return 1'b0;
    return cur;
  endfunction

  function automatic logic [ADDR_W:0] f_orig(logic [ADDR_W:0] cur, logic trap,
      logic [ADDR_W-1:0] pc, logic [LVL_W-1:0] lvl, logic we, logic sel, logic [ADDR_W-1:0] d);
    logic clr;
    clr = we && sel && (d == '0);
    if (trap && (lvl < 8) && (!cur[ADDR_W] || clr)) return {1'b1, pc};
    if (clr) return '0;
    return cur;
  endfunction

  task automatic check(string req);
    n_chk++;
    if (trap_act_o !== m_flag || orig_addr_o !== m_addr || orig_valid_o !== m_valid) begin
      n_bad++;
      $display("FAIL %s: act/addr/valid got %b/%h/%b exp %b/%h/%b", req,
               trap_act_o, orig_addr_o, orig_valid_o, m_flag, m_addr, m_valid);
    end
  endtask

  // drive at negedge, update model, then check at the following negedge
  task automatic cyc(logic trap, logic [ADDR_W-1:0] pc, logic [LVL_W-1:0] lvl,
                     logic we, logic sel, logic [ADDR_W-1:0] d, string req);
    logic [ADDR_W:0] o;
    trap_evt_i = trap; trap_pc_i = pc; cur_lvl_i = lvl;
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    m_flag = f_flag(m_flag, trap, we, sel, d);
    o = f_orig({m_valid, m_addr}, trap, pc, lvl, we, sel, d);
    {m_valid, m_addr} = o;
    @(negedge clk_i);
    check(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1");

    cyc(1, 24'hABC123, 4'd2, 0, 0, '0, "R2 R5");
    cyc(0, '0, 0, 1, 0, 24'h1, "R3 set attempt");
    cyc(0, '0, 0, 1, 0, 24'h0, "R3 clear");
    cyc(0, '0, 0, 1, 0, 24'hFFFFFF, "R3 no set");
    cyc(1, 24'h111111, 4'd0, 0, 0, '0, "R7 locked");
    cyc(0, '0, 0, 1, 1, 24'h000100, "R9 nonzero write");
    cyc(1, 24'h222222, 4'd3, 1, 0, 24'h0, "R4 collision");
    cyc(0, '0, 0, 1, 1, 24'h0, "R8 clear");
    cyc(1, 24'h333333, 4'd8, 0, 0, '0, "R6 level 8");
    cyc(1, 24'h444444, 4'd15, 0, 0, '0, "R6 level 15");
    cyc(1, 24'h555555, 4'd7, 0, 0, '0, "R5 level 7");
    cyc(1, 24'h666666, 4'd1, 1, 1, 24'h0, "R10 clear+trap");
    cyc(1, 24'h777777, 4'd9, 1, 1, 24'h0, "R8 R6 clear+high trap");

    for (int i = 0; i < N_RAND; i++) begin
      logic t, we, sel;
      logic [ADDR_W-1:0] d;
      t   = ($urandom % 6) == 0;
      we  = ($urandom % 5) == 0;
      sel = $urandom % 2;
      d   = ($urandom % 3 == 0) ? '0 : ADDR_W'($urandom);
      cyc(t, ADDR_W'($urandom), LVL_W'($urandom), we, sel, d, "R2/R3/R5/R7/R8/R9 random");
    end

    rst_ni = 1'b0;
    m_flag = 0; m_addr = '0; m_valid = 0;
    @(negedge clk_i);
    check("R1 mid-run reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule